// File: doc/BRIEF.md
# Next-PC Unit for a Fixed-Width RISC Fetch Stage

This block keeps the program counter of a simple 32-bit RISC core in which every instruction is one 32-bit word. In each enabled cycle it decodes the current instruction word and loads the next fetch address. That address is either the sequential successor, a PC-relative branch target, an absolute jump target built from the current region bits, or a full register value.

The core supplies the instruction word, a flag that says whether the two compared register operands are equal, and the register value used by jump-register. The block returns the current PC and its sequential successor. The successor is always the value computed before any jump is applied, so the core can write it as the link address of jump-and-link. A low enable freezes the PC for stalls. The synchronous reset places the PC at the start address. All pins are plain control and data levels with no handshake. The core holds the instruction stable for the whole cycle it is presented, and a stall is simply a cycle with enable low.

Top module: `npc_unit`

## Requirements
- R1: While reset is high at a rising clock edge, the PC loads 0x0040_0000. Reset takes effect whatever the enable input is.
- R2: When reset is low and enable is low at a clock edge, the PC keeps its value whatever the instruction word is.
- R3: The output pc_plus4 always equals PC + 4 modulo 2^32. In the cycle that a jump-and-link is presented it still shows that sequential value. It does not show the jump target.
- R4: An instruction whose opcode (bits 31:26) does not select one of the flow changes below, or whose opcode is 0 with a function field (bits 5:0) other than 8, loads PC + 4 modulo 2^32.
- R5: Opcode 4 (branch-if-equal) with the equality flag high loads (PC + 4) + (sign-extended bits 15:0 × 4) modulo 2^32. With the flag low it loads PC + 4.
- R6: Opcode 5 (branch-if-not-equal) with the equality flag low loads (PC + 4) + (sign-extended bits 15:0 × 4). With the flag high it loads PC + 4.
- R7: Opcodes 2 (jump) and 3 (jump-and-link) load {PC[31:28], instr[25:0], 2'b00}. The upper four bits come from the current PC and not from PC + 4, and the equality flag is ignored.
- R8: Opcode 0 with function field 8 (jump-register) loads the register value unchanged, including its two low bits.
- R9: A branch offset covers the full signed range, from -32768 words (immediate 0x8000) to +32767 words (immediate 0x7FFF).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance enable; low holds the PC |
| instr | input | 32 | Instruction word at the current PC |
| ops_equal | input | 1 | High when the two compared registers are equal |
| jreg_value | input | 32 | Register value for jump-register |
| pc | output | 32 | Current program counter |
| pc_plus4 | output | 32 | Sequential successor, also the link value |

## Verification
The assertions assume that the instruction, the equality flag and the register value are stable and known at each sampling edge. They also assume that the block has seen at least one reset cycle before its next-PC rules are checked. The bench changes inputs only on the falling edge and always applies reset first. It draws opcodes from a weighted mix of the five flow-changing codes and random others, with random immediates, targets and flags. Directed cases cover the extreme branch offsets, address wraparound, a jump taken from a non-zero region, an odd register target and stalls.

// File: rtl/npc_pkg.sv
package npc_pkg;
  localparam int unsigned OPC_W  = 6;
  localparam int unsigned FUN_W  = 6;
  localparam int unsigned IMM_W  = 16;
  localparam int unsigned JIDX_W = 26;

  localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'd0;
  localparam logic [OPC_W-1:0] OPC_JUMP    = 6'd2;
  localparam logic [OPC_W-1:0] OPC_JLINK   = 6'd3;
  localparam logic [OPC_W-1:0] OPC_BREQ    = 6'd4;
  localparam logic [OPC_W-1:0] OPC_BRNE    = 6'd5;
  localparam logic [FUN_W-1:0] FUN_JREG    = 6'd8;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BREQ,
    FLOW_BRNE,
    FLOW_JABS,
    FLOW_JREG
  } flow_e;
endpackage

// File: rtl/npc_decode.sv
module npc_decode
  import npc_pkg::*;
(
  input  logic [OPC_W-1:0] opcode,
  input  logic [FUN_W-1:0] funct,
  output flow_e            flow
);
  always_comb begin
    unique case (opcode)
      OPC_SPECIAL: flow = (funct == FUN_JREG) ? FLOW_JREG : FLOW_SEQ;
      OPC_JUMP,
      OPC_JLINK:   flow = FLOW_JABS;
      OPC_BREQ:    flow = FLOW_BREQ;
      OPC_BRNE:    flow = FLOW_BRNE;
      default:     flow = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/npc_targets.sv
module npc_targets
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0]   pc_cur,
  input  logic [IMM_W-1:0]  br_imm,
  input  logic [JIDX_W-1:0] jmp_idx,
  output logic [XLEN-1:0]   seq_addr,
  output logic [XLEN-1:0]   br_addr,
  output logic [XLEN-1:0]   abs_addr
);
  localparam int unsigned SEXT_W   = XLEN - IMM_W - 2;
  localparam int unsigned REGION_W = XLEN - JIDX_W - 2;

  logic [XLEN-1:0] br_offset;

  assign seq_addr  = pc_cur + XLEN'(4);
  assign br_offset = {{SEXT_W{br_imm[IMM_W-1]}}, br_imm, 2'b00};
  assign br_addr   = seq_addr + br_offset;
  assign abs_addr  = {pc_cur[XLEN-1 -: REGION_W], jmp_idx, 2'b00};
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  flow_e           flow,
  input  logic            ops_equal,
  input  logic [XLEN-1:0] seq_addr,
  input  logic [XLEN-1:0] br_addr,
  input  logic [XLEN-1:0] abs_addr,
  input  logic [XLEN-1:0] reg_addr,
  output logic [XLEN-1:0] next_addr
);
  always_comb begin
    unique case (flow)
      FLOW_BREQ: next_addr = ops_equal ? br_addr : seq_addr;
      FLOW_BRNE: next_addr = ops_equal ? seq_addr : br_addr;
      FLOW_JABS: next_addr = abs_addr;
      FLOW_JREG: next_addr = reg_addr;
      default:   next_addr = seq_addr;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int unsigned XLEN     = 32,
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            en,
  input  logic [31:0]     instr,
  input  logic            ops_equal,
  input  logic [XLEN-1:0] jreg_value,
  output logic [XLEN-1:0] pc,
  output logic [XLEN-1:0] pc_plus4
);
  flow_e           flow;
  logic [XLEN-1:0] seq_addr;
  logic [XLEN-1:0] br_addr;
  logic [XLEN-1:0] abs_addr;
  logic [XLEN-1:0] next_addr;
  logic [XLEN-1:0] pc_q;

  npc_decode u_decode (
    .opcode (instr[31 -: OPC_W]),
    .funct  (instr[FUN_W-1:0]),
    .flow   (flow)
  );

  npc_targets #(.XLEN(XLEN)) u_targets (
    .pc_cur   (pc_q),
    .br_imm   (instr[IMM_W-1:0]),
    .jmp_idx  (instr[JIDX_W-1:0]),
    .seq_addr (seq_addr),
    .br_addr  (br_addr),
    .abs_addr (abs_addr)
  );

  npc_select #(.XLEN(XLEN)) u_select (
    .flow      (flow),
    .ops_equal (ops_equal),
    .seq_addr  (seq_addr),
    .br_addr   (br_addr),
    .abs_addr  (abs_addr),
    .reg_addr  (jreg_value),
    .next_addr (next_addr)
  );

  always_ff @(posedge clk) begin
    if (rst)     pc_q <= XLEN'(RESET_PC);
    else if (en) pc_q <= next_addr;
  end

  assign pc       = pc_q;
  assign pc_plus4 = seq_addr;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk #(
  parameter logic [31:0] RESET_PC = 32'h0040_0000
) (
  input logic        clk,
  input logic        rst,
  input logic        en,
  input logic [31:0] instr,
  input logic        ops_equal,
  input logic [31:0] jreg_value,
  input logic [31:0] pc,
  input logic [31:0] pc_plus4
);
  logic armed = 1'b0;
  always_ff @(posedge clk) if (rst) armed <= 1'b1;

  wire        go  = en && !rst;
  wire [5:0]  opc = instr[31:26];
  wire [31:0] off = {{14{instr[15]}}, instr[15:0], 2'b00};
  wire        seq = !(opc inside {6'd2, 6'd3, 6'd4, 6'd5}) &&
                    !(opc == 6'd0 && instr[5:0] == 6'd8);

  AST_RESET_PC: assert property (@(posedge clk) rst |=> pc == RESET_PC); // R1
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst || !armed)
    !en |=> $stable(pc)); // R2
  AST_LINK_SEQ: assert property (@(posedge clk) disable iff (rst || !armed)
    go && opc == 6'd3 |=> pc != $past(pc_plus4) || $past(pc_plus4) == $past(pc) + 32'd4); // R3
  AST_SEQ_FLOW: assert property (@(posedge clk) disable iff (rst || !armed)
    go && seq |=> pc == $past(pc) + 32'd4); // R4
  AST_BREQ: assert property (@(posedge clk) disable iff (rst || !armed)
    go && opc == 6'd4 |=> pc == $past(pc) + 32'd4 + ($past(ops_equal) ? $past(off) : 32'd0)); // R5
  AST_BRNE: assert property (@(posedge clk) disable iff (rst || !armed)
    go && opc == 6'd5 |=> pc == $past(pc) + 32'd4 + ($past(ops_equal) ? 32'd0 : $past(off))); // R6
  AST_JABS: assert property (@(posedge clk) disable iff (rst || !armed)
    go && (opc == 6'd2 || opc == 6'd3) |=>
      pc == {$past(pc[31:28]), $past(instr[25:0]), 2'b00}); // R7
  AST_JREG: assert property (@(posedge clk) disable iff (rst || !armed)
    go && opc == 6'd0 && instr[5:0] == 6'd8 |=> pc == $past(jreg_value)); // R8
endmodule

bind npc_unit npc_unit_chk #(.RESET_PC(RESET_PC)) u_npc_chk (
  .clk(clk), .rst(rst), .en(en), .instr(instr), .ops_equal(ops_equal),
  .jreg_value(jreg_value), .pc(pc), .pc_plus4(pc_plus4)
);

// File: tb/npc_unit_tb_top.sv
module npc_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic [31:0] instr = 32'd0;
  logic        ops_equal = 1'b0;
  logic [31:0] jreg_value = 32'd0;
  logic [31:0] pc;
  logic [31:0] pc_plus4;

  int unsigned n_tests = 0;
  int unsigned n_fail = 0;
  logic [31:0] model_pc;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  npc_unit dut_i (
    .clk(clk), .rst(rst), .en(en), .instr(instr), .ops_equal(ops_equal),
    .jreg_value(jreg_value), .pc(pc), .pc_plus4(pc_plus4)
  );

  function automatic logic [31:0] exp_next(logic [31:0] p, logic [31:0] w,
                                           logic eq, logic [31:0] rv);
    logic [31:0] s;
    logic [31:0] b;
    s = p + 32'd4;
    b = s + {{14{w[15]}}, w[15:0], 2'b00};
    case (w[31:26])
      6'd0:       return (w[5:0] == 6'd8) ? rv : s;
      6'd2, 6'd3: return {p[31:28], w[25:0], 2'b00};
      6'd4:       return eq ? b : s;
      6'd5:       return eq ? s : b;
      default:    return s;
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic step(string tag, logic e, logic [31:0] w, logic eq, logic [31:0] rv);
    en = e; instr = w; ops_equal = eq; jreg_value = rv;
    #1;
    check({tag, " pc_plus4"}, pc_plus4, model_pc + 32'd4); // R3
    if (e) model_pc = exp_next(model_pc, w, eq, rv);
    @(negedge clk);
    check(tag, pc, model_pc);
  endtask

  task automatic do_reset(logic e);
    rst = 1'b1; en = e; instr = {6'd2, 26'h3FF_FFFF};
    @(negedge clk); @(negedge clk);
    model_pc = 32'h0040_0000;
    check("R1 reset", pc, model_pc);
    rst = 1'b0;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    logic [5:0]  op;
    void'($urandom(32'd20240531));
    @(negedge clk);
    do_reset(1'b1);
    step("R2 stall", 1'b0, {6'd2, 26'h0AB_CDEF}, 1'b1, 32'h1234_5679);
    step("R2 stall", 1'b0, {6'd0, 20'd0, 6'd8}, 1'b0, 32'hDEAD_BEE1);
    step("R4 seq", 1'b1, 32'h2000_0001, 1'b0, 32'd0);
    step("R4 op0 funct9", 1'b1, {6'd0, 20'h12345, 6'd9}, 1'b1, 32'h1111_1111);
    step("R5 beq taken", 1'b1, {6'd4, 5'd9, 5'd0, 16'd3}, 1'b1, 32'd0);
    step("R5 beq not taken", 1'b1, {6'd4, 5'd9, 5'd0, 16'd3}, 1'b0, 32'd0);
    step("R6 bne taken", 1'b1, {6'd5, 10'd0, 16'hFFFE}, 1'b0, 32'd0);
    step("R6 bne not taken", 1'b1, {6'd5, 10'd0, 16'h0040}, 1'b1, 32'd0);
    step("R9 max positive", 1'b1, {6'd4, 10'd0, 16'h7FFF}, 1'b1, 32'd0);
    step("R9 max negative", 1'b1, {6'd5, 10'd0, 16'h8000}, 1'b0, 32'd0);
    step("R8 jr odd", 1'b1, {6'd0, 20'd0, 6'd8}, 1'b0, 32'hF000_0003);
    step("R7 j region", 1'b1, {6'd2, 26'h000_0010}, 1'b1, 32'd0);
    step("R8 jr top", 1'b1, {6'd0, 20'd0, 6'd8}, 1'b1, 32'hFFFF_FFFC);
    step("R4 wrap", 1'b1, 32'hFC00_0000, 1'b0, 32'd0);
    step("R8 jr near region end", 1'b1, {6'd0, 20'd0, 6'd8}, 1'b0, 32'h7FFF_FFFC);
    step("R7 jal current region", 1'b1, {6'd3, 26'h100_0001}, 1'b0, 32'd0);
    do_reset(1'b0);
    for (int i = 0; i < 400; i++) begin
      case ($urandom_range(0, 6))
        0: op = 6'd0;
        1: op = 6'd2;
        2: op = 6'd3;
        3, 4: op = ($urandom_range(0, 1) != 0) ? 6'd4 : 6'd5;
        5: op = 6'd5;
        default: op = 6'($urandom);
      endcase
      w = {op, 26'($urandom)};
      if (op == 6'd0 && $urandom_range(0, 1) != 0) w[5:0] = 6'd8;
      step("R4 R5 R6 R7 R8 random", $urandom_range(0, 7) != 0,
           w, 1'($urandom), $urandom);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule